// File: doc/BRIEF.md
# Two-Key Service Watchdog

This block guards a processor against runaway software. Once armed during start-up, it counts clock cycles. If software does not service it before the chosen timeout, it raises a one-cycle failure pulse toward the reset sequencer. Software services it by writing two key bytes, in a fixed order, to one service address on the bus. A lone byte, a byte in the wrong order, or any other value written there leaves the count running.

Turning the watchdog on is a start-up decision. The enable input is honoured only during a short window after reset. The timeout ratio is captured at the same moment. After that, neither input can change the block's behaviour until the next reset. The count comes from a power-of-two prescaler feeding a tick counter. The tick limit is a base count multiplied by one of four ratios: 1, 4, 16 or 64.

Top module: `wdog_two_key`

## Requirements
- R1: While rst_n is low, fail_pulse is 0. Reset clears the elapsed count and the armed state, so a 0xAA key written after reset without a new 0x55 does not service.
- R2: cfg_enable is taken only on the first INIT_CYCLES (default 16) clock edges after reset release. A rising cfg_enable after that window never starts the watchdog.
- R3: Once started, the watchdog stays on until reset. Dropping cfg_enable has no effect.
- R4: cfg_period_sel is sampled on the edge that starts the watchdog. The timeout is T = 2^DIV_LOG2 × BASE_TICKS × 4^sel cycles, which is 16, 64, 256 or 1024 with the defaults. Later changes to cfg_period_sel are ignored.
- R5: Without service, fail_pulse is high for exactly one cycle, T edges after the start edge. It then repeats every T edges.
- R6: A service is a write of 0x55 to address 0x103A, followed later by a write of 0xAA to 0x103A. On the 0xAA edge the count restarts, and the next failure comes T edges after that edge. A service on an expiry edge suppresses that failure.
- R7: A 0xAA write to 0x103A when not armed has no effect on the count.
- R8: A write to 0x103A of any value other than 0x55 or 0xAA disarms. A later 0xAA does not service.
- R9: Writes to any other address neither arm, disarm nor service. They may occur between the two keys without breaking the sequence.
- R10: A watchdog that was never started never pulses fail_pulse.
- R11: Writing 0x55 again while armed keeps the block armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | AW (16) | Bus write address |
| wr_data | input | 8 | Bus write data |
| cfg_enable | input | 1 | Start request, honoured only in the start-up window |
| cfg_period_sel | input | 2 | Timeout ratio select (1, 4, 16, 64) |
| fail_pulse | output | 1 | One-cycle timeout failure toward the reset sequencer |

## Verification
Assertions check, on every cycle, the following:
- the failure pulse lasts one cycle;
- a pulse only occurs while the watchdog is enabled;
- the enable is sticky, and stays off once the start-up window has closed;
- the captured ratio stays stable;
- a service is only accepted from the armed state;
- the count is zero and no pulse follows a service.

Only the bench's scenarios can show the exact timeout lengths for each ratio, the periodic repetition of failures, and the full key-ordering cases. Those cases are a lone 0xAA, a wrong value between the keys, keys at a neighbouring address, and a repeated 0x55. The bench compares each observed pulse edge with edges it predicts from the requirements.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam logic [7:0] KEY_ARM  = 8'h55;
  localparam logic [7:0] KEY_FIRE = 8'hAA;

  // Number of ticks before expiry for a ratio select: base * 4^sel.
  function automatic int unsigned ticks_for_sel(input int unsigned base,
                                                input logic [1:0]  sel);
    return base << (2 * int'(sel));
  endfunction

  // Largest tick limit any select can request.
  function automatic int unsigned max_ticks(input int unsigned base);
    return base << 6;
  endfunction

endpackage

// File: rtl/wdog_key_seq.sv
module wdog_key_seq
  import wdog_pkg::*;
#(
  parameter int unsigned   AW       = 16,
  parameter logic [AW-1:0] SVC_ADDR = 16'h103A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  output logic          arm_q,
  output logic          svc_hit
);

  logic addr_hit;

  assign addr_hit = wr_en && (wr_addr == SVC_ADDR);
  assign svc_hit  = addr_hit && (wr_data == KEY_FIRE) && arm_q;

  // Every write to the service address rewrites the armed state:
  // only the first key arms, everything else (including the second key) disarms.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= 1'b0;
    end else if (addr_hit) begin
      arm_q <= (wr_data == KEY_ARM);
    end
  end

endmodule

// File: rtl/wdog_cfg_latch.sv
module wdog_cfg_latch #(
  parameter int unsigned INIT_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_enable,
  input  logic [1:0] cfg_period_sel,
  output logic       window_open,
  output logic       en_q,
  output logic [1:0] sel_q
);

  localparam int unsigned IW = $clog2(INIT_CYCLES + 1);

  logic [IW-1:0] init_cnt;

  assign window_open = (init_cnt < IW'(INIT_CYCLES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_cnt <= '0;
    end else if (window_open) begin
      init_cnt <= init_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sel_q <= 2'd0;
    end else if (!en_q && window_open && cfg_enable) begin
      en_q  <= 1'b1;
      sel_q <= cfg_period_sel;
    end
  end

endmodule

// File: rtl/wdog_timebase.sv
module wdog_timebase
  import wdog_pkg::*;
#(
  parameter int unsigned DIV_LOG2   = 2,
  parameter int unsigned BASE_TICKS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          restart,
  input  logic [1:0]    sel,
  output logic          expire,
  output logic [$clog2(max_ticks(BASE_TICKS) + 1)-1:0] tick_cnt
);

  localparam int unsigned CW = $clog2(max_ticks(BASE_TICKS) + 1);

  logic          tick;
  logic          clear;
  logic [CW-1:0] limit;

  assign limit  = CW'(ticks_for_sel(BASE_TICKS, sel));
  assign expire = run && tick && (tick_cnt == limit - 1'b1);
  assign clear  = !run || restart || expire;

  generate
    if (DIV_LOG2 == 0) begin : g_nodiv
      assign tick = run;
    end else begin : g_div
      logic [DIV_LOG2-1:0] pre_cnt;
      assign tick = (pre_cnt == {DIV_LOG2{1'b1}});
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pre_cnt <= '0;
        end else if (clear) begin
          pre_cnt <= '0;
        end else begin
          pre_cnt <= pre_cnt + 1'b1;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_cnt <= '0;
    end else if (clear) begin
      tick_cnt <= '0;
    end else if (tick) begin
      tick_cnt <= tick_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/wdog_two_key.sv
module wdog_two_key
  import wdog_pkg::*;
#(
  parameter int unsigned   AW          = 16,
  parameter logic [AW-1:0] SVC_ADDR    = 16'h103A,
  parameter int unsigned   DIV_LOG2    = 2,
  parameter int unsigned   BASE_TICKS  = 4,
  parameter int unsigned   INIT_CYCLES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          cfg_enable,
  input  logic [1:0]    cfg_period_sel,
  output logic          fail_pulse
);

  localparam int unsigned CW = $clog2(max_ticks(BASE_TICKS) + 1);

  logic          arm_q;
  logic          svc_hit;
  logic          window_open;
  logic          wd_en;
  logic [1:0]    sel_q;
  logic          expire;
  logic [CW-1:0] tick_cnt;

  wdog_key_seq #(
    .AW       (AW),
    .SVC_ADDR (SVC_ADDR)
  ) u_keys (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .arm_q   (arm_q),
    .svc_hit (svc_hit)
  );

  wdog_cfg_latch #(
    .INIT_CYCLES (INIT_CYCLES)
  ) u_cfg (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_enable     (cfg_enable),
    .cfg_period_sel (cfg_period_sel),
    .window_open    (window_open),
    .en_q           (wd_en),
    .sel_q          (sel_q)
  );

  wdog_timebase #(
    .DIV_LOG2   (DIV_LOG2),
    .BASE_TICKS (BASE_TICKS)
  ) u_time (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (wd_en),
    .restart  (svc_hit),
    .sel      (sel_q),
    .expire   (expire),
    .tick_cnt (tick_cnt)
  );

  // A service landing on the expiry edge wins over the failure.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_pulse <= 1'b0;
    end else begin
      fail_pulse <= expire && !svc_hit;
    end
  end

endmodule

// File: rtl/wdog_two_key_chk.sv
module wdog_two_key_chk #(
  parameter int unsigned   AW       = 16,
  parameter logic [AW-1:0] SVC_ADDR = 16'h103A,
  parameter int unsigned   CW       = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [7:0]    wr_data,
  input logic          fail_pulse,
  input logic          wd_en,
  input logic          window_open,
  input logic [1:0]    sel_q,
  input logic          arm_q,
  input logic          svc_hit,
  input logic [CW-1:0] tick_cnt
);

  // R5
  fail_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_pulse |=> !fail_pulse);

  // R10
  fail_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_pulse |-> wd_en);

  // R3
  en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_en |=> wd_en);

  // R2
  late_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!window_open && !wd_en) |=> !wd_en);

  // R4
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_en |=> $stable(sel_q));

  // R6
  svc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_hit |=> (tick_cnt == '0) && !fail_pulse);

  // R7
  svc_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_hit |-> arm_q);

  // R8
  disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == SVC_ADDR && wr_data != 8'h55) |=> !arm_q);

endmodule

bind wdog_two_key wdog_two_key_chk #(
  .AW       (AW),
  .SVC_ADDR (SVC_ADDR),
  .CW       (CW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .fail_pulse  (fail_pulse),
  .wd_en       (wd_en),
  .window_open (window_open),
  .sel_q       (sel_q),
  .arm_q       (arm_q),
  .svc_hit     (svc_hit),
  .tick_cnt    (tick_cnt)
);

// File: tb/wdog_two_key_tb.sv
module wdog_two_key_tb;

  localparam logic [15:0] SVC = 16'h103A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        cfg_enable = 1'b0;
  logic [1:0]  cfg_period_sel = 2'd0;
  logic        fail_pulse;

  int checks = 0;
  int errors = 0;
  int edge_cnt = 0;
  int exp_q[$];
  string tag_q[$];
  bit done = 1'b0;

  always #10 clk = ~clk;

  always @(posedge clk) edge_cnt <= edge_cnt + 1;

  wdog_two_key #(
    .AW(16), .SVC_ADDR(SVC), .DIV_LOG2(2), .BASE_TICKS(4), .INIT_CYCLES(16)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg_enable(cfg_enable),
    .cfg_period_sel(cfg_period_sel), .fail_pulse(fail_pulse)
  );

  // Timeout from R4, computed as a repeated multiply.
  function automatic int period(input int sel);
    int t = 4 * 4;
    for (int i = 0; i < sel; i++) t = t * 4;
    return t;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard whenever a failure pulse is seen.
  always @(negedge clk) begin
    if (rst_n && fail_pulse) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5/R6 unexpected pulse", edge_cnt, -1);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(edge_cnt == e, t, edge_cnt, e);
      end
    end
  end

  task automatic push(input int e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cfg_enable = 1'b0; wr_en = 1'b0;
    exp_q.delete(); tag_q.delete();
    repeat (3) @(negedge clk);
    chk(fail_pulse == 1'b0, "R1 reset output", fail_pulse, 0);
    rst_n = 1'b1;
  endtask

  task automatic start(input logic [1:0] sel, output int e0);
    cfg_period_sel = sel; cfg_enable = 1'b1;
    e0 = edge_cnt + 1;
    @(negedge clk);
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d, output int e);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    e = edge_cnt + 1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle(input int last, input string t);
    while (edge_cnt < last + 2) @(negedge clk);
    chk(exp_q.size() == 0, t, exp_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int e0, s, x;
    @(negedge clk);

    // R1, R10: never started, no pulse ever
    do_reset();
    repeat (300) @(negedge clk);
    settle(edge_cnt, "R10 idle no pulse");

    // R1: armed state cleared by reset
    bus_wr(SVC, 8'h55, x);
    do_reset();
    start(2'd0, e0);
    bus_wr(SVC, 8'hAA, x);
    push(e0 + period(0), "R1 armed cleared");
    settle(e0 + period(0), "R1 pulse seen");

    // R5, R3: periodic failure, enable dropped afterwards
    do_reset();
    start(2'd0, e0);
    cfg_enable = 1'b0;
    push(e0 + period(0), "R5 first expiry");
    push(e0 + 2 * period(0), "R3 R5 repeat expiry");
    settle(e0 + 2 * period(0), "R5 repeats seen");

    // R6, R9, R4: service with foreign write between keys, sel change ignored
    do_reset();
    start(2'd1, e0);
    cfg_period_sel = 2'd0;
    repeat (3) @(negedge clk);
    bus_wr(SVC, 8'h55, x);
    bus_wr(16'h1000, 8'h77, x);
    repeat (20) @(negedge clk);
    bus_wr(SVC, 8'hAA, s);
    push(s + period(1), "R6 R9 serviced");
    settle(s + period(1), "R4 R6 service restart");

    // R7, R9: keys at other address / lone second key
    do_reset();
    start(2'd1, e0);
    bus_wr(16'h103B, 8'h55, x);
    bus_wr(SVC, 8'hAA, x);
    repeat (5) @(negedge clk);
    bus_wr(SVC, 8'hAA, x);
    push(e0 + period(1), "R7 lone AA");
    settle(e0 + period(1), "R7 no service");

    // R8: wrong value between keys disarms
    do_reset();
    start(2'd1, e0);
    bus_wr(SVC, 8'h55, x);
    bus_wr(SVC, 8'h12, x);
    bus_wr(SVC, 8'hAA, x);
    push(e0 + period(1), "R8 wrong value");
    settle(e0 + period(1), "R8 no service");

    // R9: second key at neighbouring address leaves arm intact
    do_reset();
    start(2'd1, e0);
    bus_wr(SVC, 8'h55, x);
    bus_wr(16'h103B, 8'hAA, x);
    repeat (25) @(negedge clk);
    bus_wr(SVC, 8'hAA, s);
    push(s + period(1), "R9 arm kept");
    settle(s + period(1), "R9 late service");

    // R11: repeated first key
    do_reset();
    start(2'd0, e0);
    bus_wr(SVC, 8'h55, x);
    bus_wr(SVC, 8'h55, x);
    bus_wr(SVC, 8'hAA, s);
    push(s + period(0), "R11 double arm");
    settle(s + period(0), "R11 service");

    // R2: late enable ignored
    do_reset();
    repeat (20) @(negedge clk);
    start(2'd0, e0);
    repeat (200) @(negedge clk);
    settle(edge_cnt, "R2 late enable");

    // R4: longer ratios
    do_reset();
    start(2'd2, e0);
    push(e0 + period(2), "R4 sel2");
    settle(e0 + period(2), "R4 sel2 seen");
    do_reset();
    start(2'd3, e0);
    push(e0 + period(3), "R4 sel3");
    settle(e0 + period(3), "R4 sel3 seen");

    // R1: reset mid-count restarts timing
    do_reset();
    start(2'd0, e0);
    repeat (10) @(negedge clk);
    do_reset();
    start(2'd0, e0);
    push(e0 + period(0), "R1 count cleared");
    settle(e0 + period(0), "R1 restart seen");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule